// File: doc/BRIEF.md
# Sliding 3x3 Window Read-Address Sequencer

This block drives the read port of a single-port RAM that holds an image in row-major order from address 0. For every placement of a 3x3 window it issues the nine pixel addresses row by row, left to right inside each row. The window then moves one column to the right. Once the rightmost placement of a row is finished, the window returns to column 0 one row further down. The walk continues until every placement has been read. The image width and height are parameters, and the default is a 400x300 frame.

A single-cycle start pulse begins a frame. Each address is offered with a valid flag and is consumed in any cycle where the downstream ready input is high. While ready is low the sequencer holds everything it shows. Two markers frame each group of nine addresses. A done level reports that the frame is complete and stays set until the next start. The arithmetic that consumes the pixels and the RAM itself lie outside this block.

The controller has three states:
- ST_IDLE is the state after reset.
- ST_RUN is the state in which addresses are issued.
- ST_DONE is the state after a finished frame.

The transitions are:
- IDLE->RUN on start.
- RUN->RUN for every accepted address except the final one.
- RUN->DONE when the final address of the last window is accepted.
- DONE->RUN on start.
- In IDLE and DONE the state is held while start is low.

Top module: `sw_window_seq`

## Requirements
- R1: After reset, addr_valid, win_first, win_last and done are all 0.
- R2: A start pulse seen in ST_IDLE or ST_DONE makes addr_valid 1 in the next cycle, with addr 0 and win_first 1, and done 0.
- R3: Let wr be the window row start and wc the window column start. Inside a window the nine addresses are (wr+r)*W + wc + c, with r as the outer loop (0..2) and c as the inner loop (0..2). Consecutive addresses therefore step by +1 within a row and by +(W-2) between rows.
- R4: The next window starts one column right (first address +1). The exception is a window at wc = W-3: the next window starts at wc = 0, wr+1, which is first address +3.
- R5: win_first is 1 exactly on the first address of each window. win_last is 1 exactly on the ninth. Both are 0 whenever addr_valid is 0.
- R6: An address is accepted only in a cycle where addr_valid and ready are both 1. While ready is 0, addr, addr_valid, win_first and win_last keep their values.
- R7: W*H-1 is the ninth address of the window at wr = H-3, wc = W-3. In the cycle after it is accepted, addr_valid is 0 and done is 1. No further address is issued.
- R8: A start pulse while addresses are being issued is ignored, and the sequence continues unchanged.
- R9: done stays 1 until the next start. That start restarts the whole sequence from address 0.
- R10: Every issued address is below W*H.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a frame (acted on only when not running) |
| ready | input | 1 | Downstream accepts the current address |
| addr | output | ADDR_W | Read address, 0-based, row-major |
| addr_valid | output | 1 | addr is meaningful |
| win_first | output | 1 | First address of a window |
| win_last | output | 1 | Ninth address of a window |
| done | output | 1 | Frame complete, held until next start |

## Verification
Two pairs of events can fall in the same cycle, and the bench provokes both.

The first pair is a start pulse and an address acceptance. The bench raises start in the middle of a frame while ready is high. It then requires the scoreboard sequence to continue with no restart and no skipped entry. With a random ready pattern the same frame also places stalls at window and row boundaries.

The second pair is the final acceptance and the completion flag. The bench requires the scoreboard queue to be empty and done to be set in the cycle right after the last address is accepted. It also requires no further valid address after that point.

// File: rtl/sw_pkg.sv
package sw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } sw_state_e;

    localparam int KERNEL = 3;

endpackage

// File: rtl/sw_step_counter.sv
module sw_step_counter #(
    parameter int LIMIT = 3,
    parameter int STEP  = 1,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    output logic [AW-1:0] acc,
    output logic          at_zero,
    output logic          wrap
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] idx;

    assign wrap    = (idx == CW'(LIMIT - 1));
    assign at_zero = (idx == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
            acc <= '0;
        end else if (clr) begin
            idx <= '0;
            acc <= '0;
        end else if (adv) begin
            if (wrap) begin
                idx <= '0;
                acc <= '0;
            end else begin
                idx <= idx + 1'b1;
                acc <= acc + AW'(STEP);
            end
        end
    end

endmodule

// File: rtl/sw_addr_sum.sv
module sw_addr_sum #(
    parameter int AW = 8
) (
    input  logic [AW-1:0] row_base,
    input  logic [AW-1:0] col_base,
    input  logic [AW-1:0] row_off,
    input  logic [AW-1:0] col_off,
    output logic [AW-1:0] sum
);
    logic [AW-1:0] base;
    logic [AW-1:0] offs;

    always_comb begin
        base = row_base + col_base;
        offs = row_off + col_off;
        sum  = base + offs;
    end

endmodule

// File: rtl/sw_window_seq.sv
module sw_window_seq
    import sw_pkg::*;
#(
    parameter int IMG_W  = 400,
    parameter int IMG_H  = 300,
    parameter int ADDR_W = $clog2(IMG_W * IMG_H)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ready,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_valid,
    output logic              win_first,
    output logic              win_last,
    output logic              done
);
    localparam int POS_X = IMG_W - KERNEL + 1;
    localparam int POS_Y = IMG_H - KERNEL + 1;

    sw_state_e state, state_nxt;

    logic fire, clr;
    logic adv_row, adv_wcol, adv_wrow;
    logic col_wrap, row_wrap, wcol_wrap, wrow_wrap;
    logic col_zero, row_zero, wcol_zero, wrow_zero;
    logic frame_end;
    logic [ADDR_W-1:0] col_off, row_off, wcol_base, wrow_base, addr_sum;

    // control strobes for the counter chain
    always_comb begin
        fire      = (state == ST_RUN) && ready;
        clr       = start && (state != ST_RUN);
        adv_row   = fire && col_wrap;
        adv_wcol  = adv_row && row_wrap;
        adv_wrow  = adv_wcol && wcol_wrap;
        frame_end = adv_wrow && wrow_wrap;
    end

    // column inside the window: +1 each accepted address
    sw_step_counter #(.LIMIT(KERNEL), .STEP(1), .AW(ADDR_W)) u_col (
        .clk(clk), .rst_n(rst_n), .clr(clr), .adv(fire),
        .acc(col_off), .at_zero(col_zero), .wrap(col_wrap)
    );

    // row inside the window: offset accumulated by +W
    sw_step_counter #(.LIMIT(KERNEL), .STEP(IMG_W), .AW(ADDR_W)) u_row (
        .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv_row),
        .acc(row_off), .at_zero(row_zero), .wrap(row_wrap)
    );

    // window column start: stride of one column
    sw_step_counter #(.LIMIT(POS_X), .STEP(1), .AW(ADDR_W)) u_wcol (
        .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv_wcol),
        .acc(wcol_base), .at_zero(wcol_zero), .wrap(wcol_wrap)
    );

    // window row start: base accumulated by +W
    sw_step_counter #(.LIMIT(POS_Y), .STEP(IMG_W), .AW(ADDR_W)) u_wrow (
        .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv_wrow),
        .acc(wrow_base), .at_zero(wrow_zero), .wrap(wrow_wrap)
    );

    sw_addr_sum #(.AW(ADDR_W)) u_sum (
        .row_base(wrow_base),
        .col_base(wcol_base),
        .row_off (row_off),
        .col_off (col_off),
        .sum     (addr_sum)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (start)     state_nxt = ST_RUN;
            ST_RUN:  if (frame_end) state_nxt = ST_DONE;
            ST_DONE: if (start)     state_nxt = ST_RUN;
            default:                state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        addr_valid = 1'b0;
        done       = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_RUN:  addr_valid = 1'b1;
            ST_DONE: done = 1'b1;
            default: ;
        endcase
        addr      = addr_sum;
        win_first = addr_valid && col_zero && row_zero;
        win_last  = addr_valid && col_wrap && row_wrap;
    end

    logic unused_zero;
    assign unused_zero = wcol_zero ^ wrow_zero;

endmodule

// File: rtl/sw_window_seq_chk.sv
module sw_window_seq_chk #(
    parameter int IMG_W  = 400,
    parameter int IMG_H  = 300,
    parameter int ADDR_W = $clog2(IMG_W * IMG_H)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              ready,
    input logic [ADDR_W-1:0] addr,
    input logic              addr_valid,
    input logic              win_first,
    input logic              win_last,
    input logic              done
);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(IMG_W * IMG_H - 1);

    logic              fire;
    logic [3:0]        pos;
    logic [ADDR_W-1:0] base;

    assign fire = addr_valid && ready;

    // independent position-in-window tracker
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos  <= '0;
            base <= '0;
        end else begin
            if (start && !addr_valid) pos <= '0;
            else if (fire)            pos <= (pos == 4'd8) ? 4'd0 : pos + 4'd1;
            if (fire && pos == 4'd0)  base <= addr;
        end
    end

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !addr_valid) |=> (addr_valid && addr == '0 && win_first && !done));

    p_step_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && pos != 4'd2 && pos != 4'd5 && pos != 4'd8) |=> (addr == $past(addr) + ADDR_W'(1)));

    p_step_next_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (pos == 4'd2 || pos == 4'd5)) |=> (addr == $past(addr) + ADDR_W'(IMG_W - 2)));

    p_window_stride_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && win_last && addr != LAST_A) |=>
            (win_first && (addr == $past(base) + ADDR_W'(1) || addr == $past(base) + ADDR_W'(3))));

    p_markers_r5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> ((win_first == (pos == 4'd0)) && (win_last == (pos == 4'd8))));

    p_markers_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |-> (!win_first && !win_last));

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !ready) |=> (addr_valid && $stable(addr) && $stable(win_first) && $stable(win_last)));

    p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && win_last && addr == LAST_A) |=> (done && !addr_valid));

    p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(fire && win_last && addr == LAST_A));

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !ready && start) |=> $stable(addr));

    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    p_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> (addr <= LAST_A));

endmodule

bind sw_window_seq sw_window_seq_chk #(.IMG_W(IMG_W), .IMG_H(IMG_H), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/sw_window_seq_tb_top.sv
module sw_window_seq_tb_top;
    localparam int TCLK = 10;
    localparam int TW   = 6;
    localparam int TH   = 5;
    localparam int AW   = $clog2(TW * TH);

    typedef struct packed {
        logic [AW-1:0] a;
        logic          f;
        logic          l;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          ready = 1'b0;
    logic [AW-1:0] addr;
    logic          addr_valid, win_first, win_last, done;

    int   n_checks = 0;
    int   n_errors = 0;
    exp_t q[$];
    logic          prev_stall = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    logic          mon_en = 1'b0;

    always #(TCLK/2) clk = ~clk;

    sw_window_seq #(.IMG_W(TW), .IMG_H(TH)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
        .addr(addr), .addr_valid(addr_valid), .win_first(win_first),
        .win_last(win_last), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver side: expected sequence from R3/R4
    task automatic push_frame();
        for (int wr = 0; wr <= TH - 3; wr++)
            for (int wc = 0; wc <= TW - 3; wc++)
                for (int r = 0; r < 3; r++)
                    for (int c = 0; c < 3; c++)
                        q.push_back('{a: AW'((wr + r) * TW + wc + c),
                                      f: (r == 0 && c == 0),
                                      l: (r == 2 && c == 2)});
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (mon_en) begin
            if (prev_stall)
                check(addr_valid && addr == prev_addr, "R6 stall hold addr", int'(addr), int'(prev_addr));
            if (!addr_valid)
                check(!win_first && !win_last, "R5 markers low when idle", {win_first, win_last}, 0);
            if (addr_valid && ready) begin
                if (q.size() == 0) begin
                    check(1'b0, "R7 address after end of frame", int'(addr), -1);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(addr == e.a, "R3/R4 address order", int'(addr), int'(e.a));
                    check(win_first == e.f && win_last == e.l, "R5 markers",
                          {win_first, win_last}, {e.f, e.l});
                    check(int'(addr) < TW * TH, "R10 range", int'(addr), TW * TH);
                end
            end
            prev_stall = addr_valid && !ready;
            prev_addr  = addr;
        end
    end

    task automatic run_frame(input bit stall, input int mid_start);
        int cyc;
        push_frame();
        @(posedge clk); #1 start = 1'b1; ready = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        check(addr_valid && addr == '0 && win_first && !done, "R2/R9 start from 0",
              int'(addr), 0);
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk); #1;
            ready = stall ? (($urandom % 3) != 0) : 1'b1;
            start = (cyc == mid_start);
            if (cyc == mid_start) ready = 1'b1;
            cyc++;
        end
        start = 1'b0;
        @(negedge clk);
        check(done && !addr_valid, "R7 done after last", {done, addr_valid}, 2);
        check(q.size() == 0, "R7/R8 all addresses issued once", q.size(), 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(done && !addr_valid, "R9 done held", {done, addr_valid}, 2);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!addr_valid && !win_first && !win_last && !done, "R1 reset state",
              {addr_valid, win_first, win_last, done}, 0);
        rst_n = 1'b1;
        mon_en = 1'b1;
        repeat (2) @(negedge clk);
        check(!addr_valid && !done, "R1 idle after reset", {addr_valid, done}, 0);
        run_frame(1'b0, -1);
        run_frame(1'b1, 20);
        run_frame(1'b1, 57);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule